// File: doc/BRIEF.md
# Compare-Match Interval Timer with Toggle Output

This block is a small up-counting timer that advances on a clock-enable strobe supplied by an external prescaler. In interval mode the count is compared with a programmable compare value. When they meet, the counter restarts from zero and a one-cycle match interrupt is raised. A waveform flip-flop can toggle on each match, which gives a square wave on `tmr_out`. Software can also force that flip-flop low or high, or invert it, through a command register.

In PWM mode the counter instead runs freely over a power-of-two period, 2^n counts. The overflow sets the flip-flop, and the count reaching the compare value clears it. The duty is therefore compare/2^n. An overflow interrupt marks each period boundary. With double buffering enabled, compare writes are held in a buffer and only reach the active compare value at the overflow, so a duty change always starts on a period boundary. Software should finish such a write at least six clocks before the overflow.

Register map, written through `wr_en`/`wr_addr`/`wr_data`:
- Address 0 is control: bit 0 run, bit 1 toggle-on-match enable, bit 2 PWM mode, bit 3 double buffer, bits 5:4 the period shift k.
- Address 1 is the compare value, held in the low CNT_W bits.
- Address 2 is the flip-flop command, in bits 1:0.

Top module: `match_tmr`

## Requirements
- R1: In interval mode (control bit 2 = 0), a tick with count equal to the compare value C loads the count with 0. Any other tick increments it. After m ticks from zero the count is therefore m mod (C+1).
- R2: Each compare-match tick makes `irq_match` high for exactly the one cycle that follows that edge. No interrupt is raised while run (control bit 0) is 0.
- R3: In interval mode the flip-flop inverts on a match only when control bit 1 is 1. When that bit is 0 the flip-flop keeps its value across matches.
- R4: Reset (`rst_n` low at a rising edge) clears the count, the flip-flop, both interrupts, the control register and the compare value.
- R5: A write to address 2 acts on the flip-flop according to `wr_data[1:0]`: 01 clears it, 10 sets it, 00 inverts it, and 11 leaves it unchanged.
- R6: When a flip-flop command write and a hardware match or overflow fall on the same edge, only the command takes effect.
- R7: The count changes only on edges where `tick` is 1 and run is 1. While run is 0 the count is held at zero.
- R8: In PWM mode the period is P = 2^(CNT_W-k), where k is control bits 5:4. The count steps 0..P-1 and wraps to 0. Each wrap raises `irq_ovf` for one cycle.
- R9: In PWM mode, after the first overflow, `tmr_out` is 1 while the count is below the compare value C and 0 otherwise. This holds for C = 0 (output stays 0) and for C >= P (output stays 1). `irq_match` pulses when the count reaches C, for 0 < C < P.
- R10: With PWM mode and double buffering both on, a compare write changes nothing until the next overflow, where the buffered value becomes active. In every other case a compare write takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare, 2 flip-flop command |
| wr_data | input | DATA_W | Write data |
| count | output | CNT_W | Current counter value |
| tmr_out | output | 1 | Waveform flip-flop output |
| irq_match | output | 1 | One-cycle compare-match interrupt |
| irq_ovf | output | 1 | One-cycle PWM overflow interrupt |

## Verification
Every result is registered. The count, the flip-flop, both interrupts and the compare value all change on the same rising edge that samples the tick or the write causing them, so each result is due exactly one edge after its stimulus. The bench drives inputs on the falling edge and reads outputs at the next falling edge, which makes each check land on the edge that acted. The sweeps track the number of ticks m since the counter was released. Expected count, interrupt and output levels come from m mod period arithmetic, so no cycle-by-cycle model of the design is needed.

// File: rtl/tmr_pkg.sv
// Shared definitions for the compare-match timer: register addresses,
// control register layout and the flip-flop command encoding.
package tmr_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_FF   = 2'd2;
    localparam int         CTRL_W    = 6;

    // Control register, LSB first: run, toggle enable, pwm, double buffer, shift.
    typedef struct packed {
        logic [1:0] shift;
        logic       dbuf;
        logic       pwm;
        logic       tog_en;
        logic       run;
    } ctrl_t;

    // Software command for the waveform flip-flop.
    typedef enum logic [1:0] {
        FF_INV  = 2'b00,
        FF_CLR  = 2'b01,
        FF_SET  = 2'b10,
        FF_KEEP = 2'b11
    } ff_cmd_e;

endpackage

// File: rtl/tmr_counter.sv
// Up counter with event detection.
// Interval mode: the counter wraps to zero on the tick where it equals cmp_val.
// PWM mode: it wraps at top_val (overflow), and a match is flagged when the
// next count equals cmp_val.
// Assumes tick is a single-cycle enable. Events are combinational and only
// occur while run is high.
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             pwm_mode,
    input  logic [CNT_W-1:0] top_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match_ev,
    output logic             ovf_ev
);

    logic             step;
    logic             ovf_cond;
    logic [CNT_W:0]   cnt_inc;

    // Decode the events of the current tick.
    always_comb begin
        step     = run & tick;
        cnt_inc  = {1'b0, cnt} + 1'b1;
        ovf_cond = pwm_mode && (cnt >= top_val);
        ovf_ev   = step && ovf_cond;
        if (pwm_mode)
            match_ev = step && !ovf_cond && (cnt_inc == {1'b0, cmp_val});
        else
            match_ev = step && (cnt == cmp_val);
    end

    // Counter register: cleared when stopped, wraps on match or overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (step) begin
            if (ovf_ev || (!pwm_mode && match_ev))
                cnt <= '0;
            else
                cnt <= cnt_inc[CNT_W-1:0];
        end
    end

    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev && !pwm_mode) |=> (cnt == '0));                 // R1
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));                                     // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));                          // R7
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> (cnt == '0));                                   // R8

endmodule

// File: rtl/tmr_cmpreg.sv
// Compare value storage with an optional buffer stage.
// When buffered, writes land in the buffer only, and the buffer is copied
// to the active value on overflow. Otherwise writes update both at once.
// cmp_next is the active value that will hold after this edge.
module tmr_cmpreg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             buffered,
    input  logic             ovf_ev,
    output logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] cmp_next
);

    logic [CNT_W-1:0] buf_q;

    // Next active value: reload at overflow; a direct write wins.
    always_comb begin
        cmp_next = cmp_act;
        if (ovf_ev)
            cmp_next = buf_q;
        if (wr && !buffered)
            cmp_next = wdata;
    end

    // Buffer and active registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            cmp_act <= '0;
        end else begin
            if (wr)
                buf_q <= wdata;
            cmp_act <= cmp_next;
        end
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !ovf_ev) |=> $stable(cmp_act));               // R10
    AST_BUF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ev && !(wr && !buffered)) |=> (cmp_act == $past(buf_q))); // R10
    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !buffered) |=> (cmp_act == $past(wdata)));          // R10

endmodule

// File: rtl/tmr_outff.sv
// Waveform flip-flop.
// Priority order: software command, then PWM set/clear, then interval toggle.
// Assumes match_ev and ovf_ev are single-cycle events from the counter.
module tmr_outff
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic [1:0] sw_cmd,
    input  logic       pwm_mode,
    input  logic       tog_en,
    input  logic       match_ev,
    input  logic       ovf_ev,
    input  logic       ovf_val,
    output logic       q
);

    // Flip-flop update, software first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (sw_wr) begin
            case (ff_cmd_e'(sw_cmd))
                FF_CLR:  q <= 1'b0;
                FF_SET:  q <= 1'b1;
                FF_INV:  q <= ~q;
                default: q <= q;
            endcase
        end else if (pwm_mode) begin
            if (ovf_ev)
                q <= ovf_val;
            else if (match_ev)
                q <= 1'b0;
        end else if (match_ev && tog_en)
            q <= ~q;
    end

    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_cmd == 2'b01) |=> !q);                        // R5
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_cmd == 2'b10) |=> q);                         // R5
    AST_SW_INV_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_cmd == 2'b00) |=> (q != $past(q)));           // R6
    AST_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !pwm_mode && !tog_en) |=> $stable(q));          // R3

endmodule

// File: rtl/match_tmr.sv
// Compare-match timer top: register decode, interrupt registers and the
// wiring of the counter, compare storage and waveform flip-flop.
// Assumes CNT_W >= 4 (the shortest PWM period is then two counts) and
// DATA_W >= CNT_W and DATA_W >= 6.
module match_tmr
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              tmr_out,
    output logic              irq_match,
    output logic              irq_ovf
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    ctrl_t            ctrl_q;
    logic             wr_ctrl, wr_cmp, wr_ff;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] cmp_act, cmp_next;
    logic             match_ev, ovf_ev;
    logic             buffered;

    // Address decode and derived configuration.
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
        wr_cmp   = wr_en && (wr_addr == ADDR_CMP);
        wr_ff    = wr_en && (wr_addr == ADDR_FF);
        top_val  = FULL >> ctrl_q.shift;
        buffered = ctrl_q.pwm && ctrl_q.dbuf;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // One-cycle interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_match <= 1'b0;
            irq_ovf   <= 1'b0;
        end else begin
            irq_match <= match_ev;
            irq_ovf   <= ovf_ev;
        end
    end

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.run),
        .tick     (tick),
        .pwm_mode (ctrl_q.pwm),
        .top_val  (top_val),
        .cmp_val  (cmp_act),
        .cnt      (count),
        .match_ev (match_ev),
        .ovf_ev   (ovf_ev)
    );

    tmr_cmpreg #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cmp),
        .wdata    (wr_data[CNT_W-1:0]),
        .buffered (buffered),
        .ovf_ev   (ovf_ev),
        .cmp_act  (cmp_act),
        .cmp_next (cmp_next)
    );

    tmr_outff u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (wr_ff),
        .sw_cmd   (wr_data[1:0]),
        .pwm_mode (ctrl_q.pwm),
        .tog_en   (ctrl_q.tog_en),
        .match_ev (match_ev),
        .ovf_ev   (ovf_ev),
        .ovf_val  (cmp_next != '0),
        .q        (tmr_out)
    );

    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |=> !irq_ovf);                                     // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |=> (!irq_match && !irq_ovf));                 // R2

endmodule

// File: tb/match_tmr_test.sv
// Sweep bench for match_tmr with a 4-bit counter.
module match_tmr_test;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [7:0]    wr_data = 8'd0;
    logic [CW-1:0] count;
    logic          tmr_out, irq_match, irq_ovf;

    int checks = 0;
    int fails  = 0;

    match_tmr #(.CNT_W(CW), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
        .tmr_out(tmr_out), .irq_match(irq_match), .irq_ovf(irq_ovf)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int m, ph, per, exp_cnt;
        // R4 reset state
        repeat (3) cyc();
        chk(count == 0, "R4 count", int'(count), 0);
        chk(tmr_out == 0, "R4 out", int'(tmr_out), 0);
        chk(irq_match == 0 && irq_ovf == 0, "R4 irq", int'({irq_match, irq_ovf}), 0);
        rst_n = 1'b1;
        cyc();

        // R7 gating by run and tick
        wr(1, 8'd15);
        tick = 1'b1;
        repeat (3) cyc();
        chk(count == 0, "R7 stopped", int'(count), 0);
        chk(irq_match == 0, "R2 quiet when stopped", int'(irq_match), 0);
        tick = 1'b0;
        wr(0, 8'h01);
        exp_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            tick = (i % 3 == 0);
            exp_cnt += int'(tick);
            cyc();
            chk(int'(count) == exp_cnt, "R7 tick gating", int'(count), exp_cnt);
        end
        tick = 1'b0;
        wr(0, 8'h00);
        cyc();
        chk(count == 0, "R7 stop clears", int'(count), 0);

        // R1 R2 R3 interval sweep over every compare value
        for (int c = 0; c < 16; c++) begin
            tick = 1'b0;
            wr(0, 8'h00);
            wr(1, 8'(c));
            wr(2, 8'h01);
            tick = 1'b1;
            wr(0, 8'h03);
            m = 0;
            for (int j = 0; j < 3 * (c + 1) + 1; j++) begin
                cyc();
                m++;
                chk(int'(count) == m % (c + 1), "R1 count", int'(count), m % (c + 1));
                chk(int'(irq_match) == int'(m % (c + 1) == 0), "R2 irq_match",
                    int'(irq_match), int'(m % (c + 1) == 0));
                chk(int'(tmr_out) == (m / (c + 1)) % 2, "R3 toggle",
                    int'(tmr_out), (m / (c + 1)) % 2);
            end
        end

        // R3 toggle disabled
        tick = 1'b0;
        wr(0, 8'h00);
        wr(1, 8'd2);
        wr(2, 8'h01);
        tick = 1'b1;
        wr(0, 8'h01);
        for (int j = 1; j <= 9; j++) begin
            cyc();
            chk(tmr_out == 0, "R3 hold", int'(tmr_out), 0);
            chk(int'(irq_match) == int'(j % 3 == 0), "R2 irq no toggle",
                int'(irq_match), int'(j % 3 == 0));
        end

        // R5 software commands
        tick = 1'b0;
        wr(0, 8'h00);
        begin
            int cmds [6] = '{2, 0, 0, 3, 1, 3};
            int exps [6] = '{1, 0, 1, 1, 0, 0};
            for (int i = 0; i < 6; i++) begin
                wr(2, 8'(cmds[i]));
                chk(int'(tmr_out) == exps[i], "R5 command", int'(tmr_out), exps[i]);
            end
        end

        // R6 software wins over a same-edge match
        wr(1, 8'd3);
        wr(2, 8'h01);
        tick = 1'b1;
        wr(0, 8'h03);
        repeat (3) cyc();
        chk(count == 3, "R6 setup", int'(count), 3);
        wr(2, 8'h02);
        chk(tmr_out == 1, "R6 set beats toggle", int'(tmr_out), 1);
        chk(irq_match == 1, "R6 match seen", int'(irq_match), 1);
        chk(count == 0, "R6 count wrapped", int'(count), 0);
        repeat (3) cyc();
        wr(2, 8'h00);
        chk(tmr_out == 0, "R6 single inversion", int'(tmr_out), 0);

        // R8 R9 PWM sweep over every period and compare value
        for (int k = 0; k < 4; k++) begin
            per = 16 >> k;
            for (int c = 0; c <= ((per < 15) ? per : 15); c++) begin
                tick = 1'b0;
                wr(0, 8'h00);
                wr(1, 8'(c));
                tick = 1'b1;
                wr(0, 8'(5 | (k << 4)));
                m = 0;
                for (int j = 0; j < 3 * per; j++) begin
                    cyc();
                    m++;
                    ph = m % per;
                    chk(int'(count) == ph, "R8 pwm count", int'(count), ph);
                    if (m >= per) begin
                        chk(int'(irq_ovf) == int'(ph == 0), "R8 irq_ovf",
                            int'(irq_ovf), int'(ph == 0));
                        chk(int'(tmr_out) == int'(ph < c), "R9 duty",
                            int'(tmr_out), int'(ph < c));
                        chk(int'(irq_match) == int'(ph == c && c != 0 && c < per),
                            "R9 irq_match", int'(irq_match),
                            int'(ph == c && c != 0 && c < per));
                    end
                end
            end
        end

        // R10 double buffer: change deferred to overflow
        tick = 1'b0;
        wr(0, 8'h00);
        wr(1, 8'd1);
        tick = 1'b1;
        wr(0, 8'(1 | 4 | 8 | (2 << 4)));
        repeat (5) cyc();
        tick = 1'b0;
        wr(1, 8'd3);
        tick = 1'b1;
        for (int p = 2; p < 4; p++) begin
            cyc();
            chk(tmr_out == 0, "R10 old compare kept", int'(tmr_out), 0);
        end
        for (int p = 0; p < 4; p++) begin
            cyc();
            chk(int'(tmr_out) == int'(p < 3), "R10 new compare at overflow",
                int'(tmr_out), int'(p < 3));
        end
        // R10 immediate write without buffering
        cyc();
        tick = 1'b0;
        wr(0, 8'(1 | 4 | (2 << 4)));
        wr(1, 8'd2);
        tick = 1'b1;
        cyc();
        chk(tmr_out == 1, "R10 direct phase1", int'(tmr_out), 1);
        cyc();
        chk(tmr_out == 0, "R10 direct phase2", int'(tmr_out), 0);

        // R4 reset after activity
        tick = 1'b0;
        wr(2, 8'h02);
        rst_n = 1'b0;
        cyc();
        chk(tmr_out == 0, "R4 out after reset", int'(tmr_out), 0);
        chk(count == 0, "R4 count after reset", int'(count), 0);
        chk(irq_match == 0 && irq_ovf == 0, "R4 irq after reset",
            int'({irq_match, irq_ovf}), 0);
        rst_n = 1'b1;
        cyc();

        summary();
        $finish;
    end

endmodule